// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives the transmit side of a packet interface from a ring of descriptors that software prepares in shared memory. Each descriptor is three 32-bit words at a 16-byte stride: a control word carrying an ownership flag, a ring-end flag and a two-bit frame-position code, a length word with the byte count in its top half, and the byte address of the frame buffer. While its run flag is set, the engine fetches the descriptor at its ring pointer. If hardware owns it, the engine streams the buffer out as 32-bit words with a byte mask on the final word. It then rewrites the control word with ownership cleared and moves on.

The ring end is marked by a flag in the last descriptor, not by a count, so the ring can have any size. When the engine fetches a descriptor it does not own, it clears its own run flag, writes nothing, and keeps its pointer on that descriptor. Software fills in more descriptors and pulses the arm input to resume from exactly that place. The memory port is word-oriented with a fixed one-cycle read latency. The output stream uses a valid/ready handshake.

Top module: `txring_engine`

## Requirements
- R1: After reset the run flag is low, no output beat is offered and no memory read or write is issued.
- R2: A one-cycle pulse on `tx_arm_i` while stopped raises `tx_run_o` on the next clock edge and starts a fetch at the ring pointer. The first start after reset uses `list_base_i` with its low four bits forced to zero.
- R3: A descriptor at pointer P is fetched from P, P+4 and P+8. Word 0 bit 31 is the ownership flag, bit 30 is ring-end and bits 29:28 are the frame position. Word 1 bits 31:16 are the byte length. Word 2 is the buffer byte address, and its bits 1:0 are ignored, so reading starts at the enclosing aligned word. Every memory access is word aligned.
- R4: An owned descriptor of length L produces ceil(L/4) beats carrying consecutive buffer words in address order. `fo_last_o` is high on the final beat only. L = 0 produces no beat.
- R5: `fo_keep_o` bit i marks byte i (bits 8i+7:8i) as valid. It is 4'b1111 on every beat except a final beat with L mod 4 = 1, 2 or 3, which gives 4'b0001, 4'b0011 or 4'b0111.
- R6: `fo_whole_o` is high on every beat of a descriptor whose frame position is 2'b11, and low otherwise.
- R7: While `fo_valid_o` is high and `fo_ready_i` is low, the beat is held unchanged on the next cycle.
- R8: After the final beat is accepted, or after the fetch when L = 0, word 0 is written back with bit 31 cleared and all other bits unchanged. Words 1 and 2 are never written.
- R9: After a write-back, the next fetch goes to the list base if the ring-end bit was set, and to P+16 otherwise.
- R10: A fetched descriptor with bit 31 clear drops `tx_run_o`, is not written, and stays the ring pointer, so the next arm refetches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_base_i | input | AW | Byte address of the first descriptor |
| tx_arm_i | input | 1 | Pulse to set the run flag |
| tx_run_o | output | 1 | Run flag |
| mem_rd_o | output | 1 | Memory read request; data arrives on the next cycle |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| fo_valid_o | output | 1 | Output beat valid |
| fo_ready_i | input | 1 | Output beat accepted |
| fo_data_o | output | 32 | Buffer word |
| fo_keep_o | output | 4 | Valid-byte mask |
| fo_last_o | output | 1 | Final beat of the frame |
| fo_whole_o | output | 1 | Descriptor marked as a complete frame |

## Verification
A corrupted ring pointer shows up in the next descriptor fetch. It makes the engine stream the wrong buffer, or stop at the wrong slot, within a few cycles of the preceding write-back. The bench sees this as a beat-sequence mismatch or as a control word that should have been rewritten but was left alone. A wrong beat count or tail mask shows on the last beat of the frame concerned. A lost ownership check shows as a run flag that stays high, or as a write-back of a descriptor that software still owns.

// File: rtl/txr_pkg.sv
package txr_pkg;
    // Field positions in descriptor word 0
    localparam int OWN_BIT  = 31;
    localparam int END_BIT  = 30;
    localparam int POS_HI   = 29;
    localparam int POS_LO   = 28;
    localparam logic [1:0] POS_WHOLE = 2'b11;

    // Descriptor geometry in bytes
    localparam int DESC_STRIDE = 16;
    localparam int WORD_BYTES  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH1,
        ST_FETCH2,
        ST_FETCH3,
        ST_BUF_RD,
        ST_BUF_CAP,
        ST_BEAT,
        ST_WBACK
    } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic          start_i,
    input  logic          adv_i,
    input  logic          end_i,
    output logic [AW-1:0] ptr_o
);
    import txr_pkg::*;

    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(DESC_STRIDE - 1);
    localparam logic [AW-1:0] STEP       = AW'(DESC_STRIDE);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          fresh;
    } ptr_state_t;

    ptr_state_t cur_q, cur_d;
    logic [AW-1:0] base_al;

    always_comb begin
        base_al = base_i & ALIGN_MASK;
        cur_d   = cur_q;
        if (start_i && cur_q.fresh) begin
            cur_d.ptr   = base_al;
            cur_d.fresh = 1'b0;
        end else if (adv_i) begin
            cur_d.ptr = end_i ? base_al : (cur_q.ptr + STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.ptr   <= '0;
            cur_q.fresh <= 1'b1;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign ptr_o = cur_q.ptr;

    // R9
    stride_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.fresh |-> (cur_q.ptr[3:0] == 4'd0));
endmodule

// File: rtl/txr_beat_gen.sv
module txr_beat_gen #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] len_i,
    input  logic [AW-3:0] buf_word_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o,
    output logic [3:0]    keep_o
);
    localparam int CW = LW - 1;

    typedef struct packed {
        logic [AW-3:0] waddr;
        logic [CW-1:0] left;
        logic [1:0]    tail;
    } beat_state_t;

    beat_state_t st_q, st_d;
    logic [LW:0] len_round;

    always_comb begin
        len_round = {1'b0, len_i} + (LW+1)'(3);
        st_d      = st_q;
        if (load_i) begin
            st_d.waddr = buf_word_i;
            st_d.left  = len_round[LW:2];
            st_d.tail  = len_i[1:0];
        end else if (step_i) begin
            st_d.waddr = st_q.waddr + 1'b1;
            st_d.left  = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        last_o = (st_q.left == CW'(1));
        if (last_o && (st_q.tail != 2'd0)) begin
            keep_o = ~(4'hF << st_q.tail);
        end else begin
            keep_o = 4'hF;
        end
    end

    assign addr_o = {st_q.waddr, 2'b00};

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (st_q.left != '0));
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] beat_addr_i,
    input  logic          beat_last_i,
    input  logic [31:0]   mem_rdata_i,
    input  logic          fo_ready_i,
    output logic          run_o,
    output logic          start_o,
    output logic          adv_o,
    output logic          end_o,
    output logic          beat_load_o,
    output logic [LW-1:0] beat_len_o,
    output logic [AW-3:0] beat_buf_o,
    output logic          beat_step_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    output logic          fo_valid_o,
    output logic [31:0]   fo_data_o,
    output logic          fo_whole_o
);
    import txr_pkg::*;

    localparam logic [AW-1:0] OFS_W1 = AW'(WORD_BYTES);
    localparam logic [AW-1:0] OFS_W2 = AW'(2 * WORD_BYTES);

    typedef struct packed {
        txr_state_e    state;
        logic          run;
        logic [31:0]   ctl;
        logic [LW-1:0] len;
        logic [31:0]   data;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        start_o     = 1'b0;
        adv_o       = 1'b0;
        end_o       = st_q.ctl[END_BIT];
        beat_load_o = 1'b0;
        beat_len_o  = st_q.len;
        beat_buf_o  = mem_rdata_i[AW-1:2];
        beat_step_o = 1'b0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = ptr_i;
        mem_wdata_o = st_q.ctl;
        mem_wdata_o[OWN_BIT] = 1'b0;
        fo_valid_o  = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (arm_i) begin
                    st_d.run   = 1'b1;
                    start_o    = 1'b1;
                    st_d.state = ST_FETCH0;
                end
            end
            ST_FETCH0: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = ptr_i;
                st_d.state = ST_FETCH1;
            end
            ST_FETCH1: begin
                if (!mem_rdata_i[OWN_BIT]) begin
                    st_d.run   = 1'b0;
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.ctl   = mem_rdata_i;
                    mem_rd_o   = 1'b1;
                    mem_addr_o = ptr_i + OFS_W1;
                    st_d.state = ST_FETCH2;
                end
            end
            ST_FETCH2: begin
                st_d.len   = mem_rdata_i[31:32-LW];
                mem_rd_o   = 1'b1;
                mem_addr_o = ptr_i + OFS_W2;
                st_d.state = ST_FETCH3;
            end
            ST_FETCH3: begin
                beat_load_o = 1'b1;
                st_d.state  = (st_q.len == '0) ? ST_WBACK : ST_BUF_RD;
            end
            ST_BUF_RD: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = beat_addr_i;
                st_d.state = ST_BUF_CAP;
            end
            ST_BUF_CAP: begin
                st_d.data  = mem_rdata_i;
                st_d.state = ST_BEAT;
            end
            ST_BEAT: begin
                fo_valid_o = 1'b1;
                if (fo_ready_i) begin
                    beat_step_o = 1'b1;
                    st_d.state  = beat_last_i ? ST_WBACK : ST_BUF_RD;
                end
            end
            ST_WBACK: begin
                mem_wr_o   = 1'b1;
                mem_addr_o = ptr_i;
                adv_o      = 1'b1;
                st_d.state = ST_FETCH0;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.run   <= 1'b0;
            st_q.ctl   <= '0;
            st_q.len   <= '0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = st_q.run;
    assign fo_data_o  = st_q.data;
    assign fo_whole_o = (st_q.ctl[POS_HI:POS_LO] == POS_WHOLE);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_valid_o && !fo_ready_i) |=> (fo_valid_o && $stable(fo_data_o)));

    // R8
    wback_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> !mem_wdata_o[OWN_BIT]);

    // R10
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (!fo_valid_o && !mem_wr_o));

    // R3
    aligned_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (mem_addr_o[1:0] == 2'b00));

    // R3
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] list_base_i,
    input  logic          tx_arm_i,
    output logic          tx_run_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          fo_valid_o,
    input  logic          fo_ready_i,
    output logic [31:0]   fo_data_o,
    output logic [3:0]    fo_keep_o,
    output logic          fo_last_o,
    output logic          fo_whole_o
);
    logic          start_w;
    logic          adv_w;
    logic          end_w;
    logic [AW-1:0] ptr_w;
    logic          load_w;
    logic [LW-1:0] len_w;
    logic [AW-3:0] bufw_w;
    logic          step_w;
    logic [AW-1:0] baddr_w;
    logic          blast_w;
    logic [3:0]    bkeep_w;

    txr_ring_ptr #(.AW(AW)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_i  (list_base_i),
        .start_i (start_w),
        .adv_i   (adv_w),
        .end_i   (end_w),
        .ptr_o   (ptr_w)
    );

    txr_beat_gen #(.AW(AW), .LW(LW)) beat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .len_i      (len_w),
        .buf_word_i (bufw_w),
        .step_i     (step_w),
        .addr_o     (baddr_w),
        .last_o     (blast_w),
        .keep_o     (bkeep_w)
    );

    txr_ctrl #(.AW(AW), .LW(LW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (tx_arm_i),
        .ptr_i       (ptr_w),
        .beat_addr_i (baddr_w),
        .beat_last_i (blast_w),
        .mem_rdata_i (mem_rdata_i),
        .fo_ready_i  (fo_ready_i),
        .run_o       (tx_run_o),
        .start_o     (start_w),
        .adv_o       (adv_w),
        .end_o       (end_w),
        .beat_load_o (load_w),
        .beat_len_o  (len_w),
        .beat_buf_o  (bufw_w),
        .beat_step_o (step_w),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .fo_valid_o  (fo_valid_o),
        .fo_data_o   (fo_data_o),
        .fo_whole_o  (fo_whole_o)
    );

    assign fo_keep_o = fo_valid_o ? bkeep_w : 4'h0;
    assign fo_last_o = fo_valid_o && blast_w;

    // R5
    keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_valid_o && !fo_last_o) |-> (fo_keep_o == 4'hF));

    // R4
    beat_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fo_valid_o |-> tx_run_o);
endmodule

// File: tb/txring_engine_tb_top.sv
module txring_engine_tb_top;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int BASE = 32'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_arm = 1'b0;
    logic tx_run;
    logic mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic fo_valid;
    logic fo_ready = 1'b0;
    logic [31:0] fo_data;
    logic [3:0] fo_keep;
    logic fo_last, fo_whole;

    always #10 clk = ~clk;

    txring_engine #(.AW(AW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .list_base_i(BASE), .tx_arm_i(tx_arm), .tx_run_o(tx_run),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .fo_valid_o(fo_valid), .fo_ready_i(fo_ready),
        .fo_data_o(fo_data), .fo_keep_o(fo_keep), .fo_last_o(fo_last), .fo_whole_o(fo_whole)
    );

    logic [31:0] mem [0:1023];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    end

    int checks = 0;
    int errors = 0;
    int exp_idx = 0;
    int exp_n, got_n;
    logic [31:0] exp_d [0:255];
    logic [3:0]  exp_k [0:255];
    logic        exp_l [0:255];
    logic        exp_w [0:255];
    logic [31:0] got_d [0:255];
    logic [3:0]  got_k [0:255];
    logic        got_l [0:255];
    logic        got_w [0:255];
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    int          ready_pct = 70;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive ready and sample the beat the next edge will transfer
    always @(negedge clk) begin
        fo_ready = ($urandom_range(0, 99) < ready_pct);
        if (prev_stall) check(fo_valid && (fo_data == prev_data), "R7 stall hold", fo_data, prev_data);
        prev_stall = fo_valid && !fo_ready;
        prev_data  = fo_data;
        if (fo_valid && fo_ready && got_n < 256) begin
            got_d[got_n] = fo_data;
            got_k[got_n] = fo_keep;
            got_l[got_n] = fo_last;
            got_w[got_n] = fo_whole;
            got_n++;
        end
    end

    function automatic logic [3:0] exp_keep(input int len, input int j, input int n);
        if (j == n - 1 && (len % 4) != 0) return 4'((1 << (len % 4)) - 1);
        return 4'hF;
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic scenario(input int nact, input int fixlen, input int fixoff);
        logic [31:0] w0 [0:3];
        logic [31:0] w1 [0:3];
        logic [31:0] w2 [0:3];
        logic [31:0] ew0 [0:3];
        int idx, guard;
        bit seen_run;
        for (int i = 0; i < 4; i++) begin
            int len, off, bw;
            len = (fixlen >= 0) ? fixlen : $urandom_range(0, 40);
            off = (fixoff >= 0) ? fixoff : $urandom_range(0, 3);
            w0[i] = {1'b0, (i == 3), 2'($urandom_range(0, 3)), 28'($urandom)};
            w1[i] = {16'(len), 16'($urandom)};
            w2[i] = 32'h400 + 32'(i * 64 + off);
            bw = (32'h400 + i * 64) / 4;
            for (int k = 0; k < 16; k++) mem[bw + k] = $urandom;
        end
        for (int k = 0; k < nact; k++) w0[(exp_idx + k) % 4][31] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            mem[BASE / 4 + i * 4]     = w0[i];
            mem[BASE / 4 + i * 4 + 1] = w1[i];
            mem[BASE / 4 + i * 4 + 2] = w2[i];
            ew0[i] = w0[i];
        end
        // Expected stream from the descriptor rules
        exp_n = 0;
        idx = exp_idx;
        while (ew0[idx][31]) begin
            int len, n, bw;
            len = int'(w1[idx][31:16]);
            n = (len + 3) / 4;
            bw = int'(w2[idx][11:2]);
            for (int j = 0; j < n; j++) begin
                exp_d[exp_n] = mem[bw + j];
                exp_k[exp_n] = exp_keep(len, j, n);
                exp_l[exp_n] = (j == n - 1);
                exp_w[exp_n] = (w0[idx][29:28] == 2'b11);
                exp_n++;
            end
            ew0[idx][31] = 1'b0;
            idx = ew0[idx][30] ? 0 : idx + 1;
        end
        exp_idx = idx;
        got_n = 0;
        @(negedge clk);
        tx_arm = 1'b1;
        @(negedge clk);
        tx_arm = 1'b0;
        seen_run = tx_run;
        check(tx_run, "R2 run raised by arm", 32'(tx_run), 32'd1);
        guard = 0;
        while (tx_run && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) begin
            check(1'b0, "R10 run never dropped", 32'(tx_run), 32'd0);
            finish_run();
        end
        repeat (2) @(negedge clk);
        check(got_n == exp_n, "R4 beat count", 32'(got_n), 32'(exp_n));
        for (int j = 0; j < exp_n && j < got_n; j++) begin
            check(got_d[j] == exp_d[j], "R3 R4 R9 beat data", got_d[j], exp_d[j]);
            check(got_k[j] == exp_k[j], "R5 keep", 32'(got_k[j]), 32'(exp_k[j]));
            check(got_l[j] == exp_l[j], "R4 last", 32'(got_l[j]), 32'(exp_l[j]));
            check(got_w[j] == exp_w[j], "R6 whole", 32'(got_w[j]), 32'(exp_w[j]));
        end
        for (int i = 0; i < 4; i++) begin
            check(mem[BASE / 4 + i * 4] == ew0[i], "R8 R10 control word", mem[BASE / 4 + i * 4], ew0[i]);
            check(mem[BASE / 4 + i * 4 + 1] == w1[i], "R8 word1 untouched", mem[BASE / 4 + i * 4 + 1], w1[i]);
            check(mem[BASE / 4 + i * 4 + 2] == w2[i], "R8 word2 untouched", mem[BASE / 4 + i * 4 + 2], w2[i]);
        end
        check(!tx_run && seen_run, "R10 stopped", 32'(tx_run), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!tx_run, "R1 run low", 32'(tx_run), 32'd0);
        check(!fo_valid, "R1 no beat", 32'(fo_valid), 32'd0);
        check(!mem_rd && !mem_wr, "R1 no access", {30'd0, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!tx_run && !mem_rd && !mem_wr, "R1 idle after reset", 32'(tx_run), 32'd0);
        scenario(1, 8, 0);    // R2 first arm at base
        scenario(1, 13, 3);   // R3 misaligned buffer, R5 tail mask
        scenario(1, 0, -1);   // R4 zero length
        scenario(0, -1, -1);  // R10 nothing owned
        scenario(4, -1, -1);  // R9 full lap through the ring end
        ready_pct = 100;
        scenario(3, 6, 2);
        ready_pct = 40;
        for (int r = 0; r < 20; r++) scenario($urandom_range(0, 4), -1, -1);
        finish_run();
    end
endmodule